// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers the eight interrupt sources of a two-channel serial controller into one status byte. It combines that byte with a software-loaded mask to drive a single active-low interrupt request. Two kinds of source feed it. Level sources compare a FIFO occupancy count against a programmed trigger and follow that comparison every cycle. Sticky sources latch an event and hold it until their own clearing action arrives: a command nibble, a stop command, or a read strobe from the change register. The FIFOs, the break detector and the counter/timer sit outside the block and reach it only as input signals.

Each source is a small named state machine. A level source has the states `LVL_LOW` and `LVL_MET`. It moves to `LVL_MET` when the comparison holds and back to `LVL_LOW` when it fails. A sticky source has the states `SRC_IDLE` and `SRC_PENDING`. A set event moves it from `SRC_IDLE` to `SRC_PENDING`. A clear event with no set event in the same cycle moves it back to `SRC_IDLE`. The input-port watcher passes four external pins through a synchronizer and an edge detector. It keeps one sticky change-pending machine per pin and one sticky machine for the summary bit.

Top module: `irq_status_agg`

## Requirements
- R1: The status byte has this bit layout: 0 = transmit ready A, 1 = receive ready A, 2 = break change A, 3 = counter/timer ready, 4 = transmit ready B, 5 = receive ready B, 6 = break change B, 7 = input port change. `irq_n` is low exactly when some bit is 1 in both `status_o` and `mask_o`.
- R2: A cycle with `mask_we` high loads `mask_wdata` into `mask_o`, and the new value is visible after that clock edge.
- R3: Bits 0 and 4 are 1 one cycle after the channel's free TX count is greater than or equal to its TX trigger, and 0 one cycle after it is less.
- R4: Bits 1 and 5 are 1 one cycle after the channel's RX fill count is greater than or equal to its RX trigger, and 0 one cycle after it is less.
- R5: Bits 2 and 6 set one cycle after a pulse on that channel's break-edge input and then hold. They clear only when that channel's command strobe carries the nibble 4'h5. Any other nibble leaves them set.
- R6: Bit 3 sets one cycle after a counter/timer ready pulse and holds until a stop-counter command clears it.
- R7: A change on input pin k is seen three clock edges after it occurs. It then sets `port_delta[k]` whatever the enables are. It sets bit 7 only if `port_chg_en[k]` is 1. A `port_chg_rd` pulse clears bit 7 and all of `port_delta`.
- R8: When a sticky bit (2, 3, 6, 7 or a `port_delta` bit) sees its set event and its clear event in the same cycle, it ends that cycle set.
- R9: After reset, `status_o`, `mask_o` and `port_delta` are all zero and `irq_n` is high.
- R10: `status_o` shows every active source whatever the mask is. The status byte has no read strobe, so observing it never clears a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Mask load strobe |
| mask_wdata | input | 8 | New mask value |
| tx_free_a | input | LVL_W | Empty locations in TX FIFO A |
| tx_trig_a | input | LVL_W | TX trigger level A |
| rx_fill_a | input | LVL_W | Bytes held in RX FIFO A |
| rx_trig_a | input | LVL_W | RX trigger level A |
| tx_free_b | input | LVL_W | Empty locations in TX FIFO B |
| tx_trig_b | input | LVL_W | TX trigger level B |
| rx_fill_b | input | LVL_W | Bytes held in RX FIFO B |
| rx_trig_b | input | LVL_W | RX trigger level B |
| brk_edge_a | input | 1 | Pulse at the start or end of a break on channel A |
| brk_edge_b | input | 1 | Pulse at the start or end of a break on channel B |
| cmd_we_a | input | 1 | Command strobe, channel A |
| cmd_a | input | 4 | Command nibble, channel A |
| cmd_we_b | input | 1 | Command strobe, channel B |
| cmd_b | input | 4 | Command nibble, channel B |
| ct_ready | input | 1 | Counter/timer ready pulse |
| ct_stop | input | 1 | Stop-counter command pulse |
| port_pins | input | NPINS | Asynchronous input pins |
| port_chg_en | input | NPINS | Per-pin change interrupt enable |
| port_chg_rd | input | 1 | Read strobe of the change register |
| port_delta | output | NPINS | Per-pin change-pending flags |
| status_o | output | 8 | Interrupt status byte |
| mask_o | output | 8 | Interrupt mask byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default parameters: 4-bit FIFO counts, four input pins and a two-flop synchronizer. A 4-bit count lets the vectors reach the comparison edges at zero, at full scale (15) and at equality. A two-stage synchronizer fixes the pin-to-status delay at three edges. That delay lets the bench place a change-register read in exactly the cycle where a pin change is seen, which tests set-over-clear priority on the port bits.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC = 8;

    localparam int BIT_TXA = 0;
    localparam int BIT_RXA = 1;
    localparam int BIT_BRA = 2;
    localparam int BIT_CT  = 3;
    localparam int BIT_TXB = 4;
    localparam int BIT_RXB = 5;
    localparam int BIT_BRB = 6;
    localparam int BIT_IPC = 7;

    typedef logic [NSRC-1:0] irq_vec_t;

    typedef enum logic {
        SRC_IDLE    = 1'b0,
        SRC_PENDING = 1'b1
    } src_state_t;

    typedef enum logic {
        LVL_LOW = 1'b0,
        LVL_MET = 1'b1
    } lvl_state_t;

endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    src_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE:    if (set_i)           state_d = SRC_PENDING;
            SRC_PENDING: if (clr_i && !set_i) state_d = SRC_IDLE;
            default:                          state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == SRC_PENDING);
    end

    // set event is never lost, even against a simultaneous clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // a clear with no set always releases the bit
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/irq_level_src.sv
module irq_level_src
    import irq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] trig_i,
    output logic         ready_o
);

    lvl_state_t state_q, state_d;
    logic       meets;

    assign meets = (count_i >= trig_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW: if (meets)  state_d = LVL_MET;
            LVL_MET: if (!meets) state_d = LVL_LOW;
            default:             state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        ready_o = (state_q == LVL_MET);
    end

    assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ready_o == $past(count_i >= trig_i)));

endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch
    import irq_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_i,
    input  logic [NPINS-1:0] en_i,
    input  logic             rd_i,
    output logic [NPINS-1:0] delta_o,
    output logic             chg_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [NPINS-1:0] sync_q [SYNC_STAGES];
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] edge_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= pins_i;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[LAST];
    end

    assign edge_w = sync_q[LAST] ^ prev_q;

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        irq_sticky_bit u_delta (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (edge_w[k]),
            .clr_i  (rd_i),
            .flag_o (delta_o[k])
        );
    end

    irq_sticky_bit u_summary (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (|(edge_w & en_i)),
        .clr_i  (rd_i),
        .flag_o (chg_o)
    );

    // the summary bit never sets without a recorded enabled change
    assert_summary_has_delta_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_o) |-> (|(delta_o & $past(en_i))));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && edge_w == '0) |=> (delta_o == '0 && !chg_o));

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_pkg::*;
#(
    parameter int         LVL_W       = 4,
    parameter int         NPINS       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] CLR_CODE    = 4'h5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [7:0]       mask_wdata,
    input  logic [LVL_W-1:0] tx_free_a,
    input  logic [LVL_W-1:0] tx_trig_a,
    input  logic [LVL_W-1:0] rx_fill_a,
    input  logic [LVL_W-1:0] rx_trig_a,
    input  logic [LVL_W-1:0] tx_free_b,
    input  logic [LVL_W-1:0] tx_trig_b,
    input  logic [LVL_W-1:0] rx_fill_b,
    input  logic [LVL_W-1:0] rx_trig_b,
    input  logic             brk_edge_a,
    input  logic             brk_edge_b,
    input  logic             cmd_we_a,
    input  logic [3:0]       cmd_a,
    input  logic             cmd_we_b,
    input  logic [3:0]       cmd_b,
    input  logic             ct_ready,
    input  logic             ct_stop,
    input  logic [NPINS-1:0] port_pins,
    input  logic [NPINS-1:0] port_chg_en,
    input  logic             port_chg_rd,
    output logic [NPINS-1:0] port_delta,
    output logic [7:0]       status_o,
    output logic [7:0]       mask_o,
    output logic             irq_n
);

    irq_vec_t status_w;
    irq_vec_t mask_q;
    logic     brk_clr_a, brk_clr_b;

    assign brk_clr_a = cmd_we_a && (cmd_a == CLR_CODE);
    assign brk_clr_b = cmd_we_b && (cmd_b == CLR_CODE);

    irq_level_src #(.W(LVL_W)) u_txa (
        .clk(clk), .rst_n(rst_n), .count_i(tx_free_a), .trig_i(tx_trig_a),
        .ready_o(status_w[BIT_TXA]));
    irq_level_src #(.W(LVL_W)) u_rxa (
        .clk(clk), .rst_n(rst_n), .count_i(rx_fill_a), .trig_i(rx_trig_a),
        .ready_o(status_w[BIT_RXA]));
    irq_level_src #(.W(LVL_W)) u_txb (
        .clk(clk), .rst_n(rst_n), .count_i(tx_free_b), .trig_i(tx_trig_b),
        .ready_o(status_w[BIT_TXB]));
    irq_level_src #(.W(LVL_W)) u_rxb (
        .clk(clk), .rst_n(rst_n), .count_i(rx_fill_b), .trig_i(rx_trig_b),
        .ready_o(status_w[BIT_RXB]));

    irq_sticky_bit u_bra (
        .clk(clk), .rst_n(rst_n), .set_i(brk_edge_a), .clr_i(brk_clr_a),
        .flag_o(status_w[BIT_BRA]));
    irq_sticky_bit u_brb (
        .clk(clk), .rst_n(rst_n), .set_i(brk_edge_b), .clr_i(brk_clr_b),
        .flag_o(status_w[BIT_BRB]));
    irq_sticky_bit u_ct (
        .clk(clk), .rst_n(rst_n), .set_i(ct_ready), .clr_i(ct_stop),
        .flag_o(status_w[BIT_CT]));

    irq_port_watch #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (port_pins),
        .en_i    (port_chg_en),
        .rd_i    (port_chg_rd),
        .delta_o (port_delta),
        .chg_o   (status_w[BIT_IPC])
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    always_comb begin
        status_o = status_w;
        mask_o   = mask_q;
        irq_n    = ~|(status_w & mask_q);
    end

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_o == $past(mask_wdata)));

    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_o));

    assert_brk_other_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[BIT_BRA] && !(cmd_we_a && cmd_a == CLR_CODE)) |=> status_o[BIT_BRA]);

    assert_ct_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_stop && !ct_ready) |=> !status_o[BIT_CT]);

endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [3:0] tx_free_a = '0, tx_trig_a = '0, rx_fill_a = '0, rx_trig_a = '0;
    logic [3:0] tx_free_b = '0, tx_trig_b = '0, rx_fill_b = '0, rx_trig_b = '0;
    logic       brk_edge_a = 1'b0, brk_edge_b = 1'b0;
    logic       cmd_we_a = 1'b0, cmd_we_b = 1'b0;
    logic [3:0] cmd_a = '0, cmd_b = '0;
    logic       ct_ready = 1'b0, ct_stop = 1'b0;
    logic [3:0] port_pins = '0, port_chg_en = '0;
    logic       port_chg_rd = 1'b0;
    logic [3:0] port_delta;
    logic [7:0] status_o, mask_o;
    logic       irq_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_status_agg dut (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .tx_free_a(tx_free_a), .tx_trig_a(tx_trig_a), .rx_fill_a(rx_fill_a), .rx_trig_a(rx_trig_a),
        .tx_free_b(tx_free_b), .tx_trig_b(tx_trig_b), .rx_fill_b(rx_fill_b), .rx_trig_b(rx_trig_b),
        .brk_edge_a(brk_edge_a), .brk_edge_b(brk_edge_b),
        .cmd_we_a(cmd_we_a), .cmd_a(cmd_a), .cmd_we_b(cmd_we_b), .cmd_b(cmd_b),
        .ct_ready(ct_ready), .ct_stop(ct_stop),
        .port_pins(port_pins), .port_chg_en(port_chg_en), .port_chg_rd(port_chg_rd),
        .port_delta(port_delta), .status_o(status_o), .mask_o(mask_o), .irq_n(irq_n));

    // {tx_free, tx_trig, rx_fill, rx_trig, exp_tx, exp_rx}
    localparam logic [17:0] VEC [6] = '{
        {4'd4,  4'd4,  4'd5,  4'd6,  1'b1, 1'b0},
        {4'd3,  4'd4,  4'd6,  4'd6,  1'b0, 1'b1},
        {4'd0,  4'd0,  4'd0,  4'd0,  1'b1, 1'b1},
        {4'd8,  4'd1,  4'd7,  4'd8,  1'b1, 1'b0},
        {4'd1,  4'd2,  4'd8,  4'd2,  1'b0, 1'b1},
        {4'd15, 4'd15, 4'd14, 4'd15, 1'b1, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tx_trig_a = 4'd1; tx_trig_b = 4'd1; rx_trig_a = 4'd1; rx_trig_b = 4'd1;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9: reset state
        chk("R9 status", status_o, 8'h00);
        chk("R9 mask", mask_o, 8'h00);
        chk("R9 delta", port_delta, 4'h0);
        chk("R9 irq_n", irq_n, 1'b1);

        // R2: mask load
        mask_we = 1'b1; mask_wdata = 8'hFF;
        step(1);
        mask_we = 1'b0;
        chk("R2 mask", mask_o, 8'hFF);

        // R3/R4/R1 vector table on both channels
        for (int i = 0; i < 6; i++) begin
            tx_free_a = VEC[i][17:14]; tx_trig_a = VEC[i][13:10];
            rx_fill_a = VEC[i][9:6];   rx_trig_a = VEC[i][5:2];
            tx_free_b = VEC[i][9:6];   tx_trig_b = VEC[i][5:2];
            rx_fill_b = VEC[i][17:14]; rx_trig_b = VEC[i][13:10];
            step(1);
            chk("R3 txA", status_o[0], VEC[i][1]);
            chk("R4 rxA", status_o[1], VEC[i][0]);
            chk("R3 txB", status_o[4], VEC[i][0]);
            chk("R4 rxB", status_o[5], VEC[i][1]);
            chk("R1 irq_n", irq_n, !(VEC[i][1] | VEC[i][0]));
        end
        // quiet level sources
        tx_free_a = 0; tx_trig_a = 1; rx_fill_a = 0; rx_trig_a = 1;
        tx_free_b = 0; tx_trig_b = 1; rx_fill_b = 0; rx_trig_b = 1;
        step(1);
        chk("R3 quiet", status_o, 8'h00);

        // R5: break change A, wrong code ignored, right code clears
        brk_edge_a = 1'b1; step(1); brk_edge_a = 1'b0;
        chk("R5 brkA set", status_o, 8'h04);
        step(2);
        chk("R5 brkA held", status_o, 8'h04);
        cmd_we_a = 1'b1; cmd_a = 4'h4; step(1);
        chk("R5 wrong code", status_o[2], 1'b1);
        cmd_a = 4'h5; cmd_we_b = 1'b1; cmd_b = 4'h5; step(1);
        cmd_we_a = 1'b0; cmd_we_b = 1'b0;
        chk("R5 brkA clear", status_o[2], 1'b0);
        brk_edge_b = 1'b1; step(1); brk_edge_b = 1'b0;
        chk("R5 brkB set", status_o, 8'h40);
        cmd_we_a = 1'b1; cmd_a = 4'h5; step(1); cmd_we_a = 1'b0;
        chk("R5 other channel cmd", status_o[6], 1'b1);
        // R8: set and clear together on break B
        brk_edge_b = 1'b1; cmd_we_b = 1'b1; cmd_b = 4'h5; step(1);
        brk_edge_b = 1'b0; step(1); cmd_we_b = 1'b0;
        chk("R5 brkB clear", status_o[6], 1'b0);
        brk_edge_b = 1'b1; cmd_we_b = 1'b1; step(1);
        brk_edge_b = 1'b0; cmd_we_b = 1'b0;
        chk("R8 brk set wins", status_o[6], 1'b1);
        cmd_we_b = 1'b1; step(1); cmd_we_b = 1'b0;

        // R6: counter/timer
        ct_ready = 1'b1; step(1); ct_ready = 1'b0;
        chk("R6 ct set", status_o, 8'h08);
        step(2);
        chk("R6 ct held", status_o[3], 1'b1);
        // R10: masked bit stays visible, irq high
        mask_we = 1'b1; mask_wdata = 8'hF7; step(1); mask_we = 1'b0;
        chk("R10 visible", status_o[3], 1'b1);
        chk("R1 masked irq", irq_n, 1'b1);
        mask_we = 1'b1; mask_wdata = 8'h08; step(1); mask_we = 1'b0;
        chk("R1 unmasked irq", irq_n, 1'b0);
        ct_ready = 1'b1; ct_stop = 1'b1; step(1); ct_ready = 1'b0;
        chk("R8 ct set wins", status_o[3], 1'b1);
        step(1); ct_stop = 1'b0;
        chk("R6 ct stop", status_o[3], 1'b0);

        // R7: input port change
        port_chg_en = 4'b0001;
        port_pins[2] = 1'b1; step(2);
        chk("R7 not yet", port_delta, 4'h0);
        step(1);
        chk("R7 delta disabled pin", port_delta, 4'b0100);
        chk("R7 no bit7", status_o[7], 1'b0);
        port_chg_rd = 1'b1; step(1); port_chg_rd = 1'b0;
        chk("R7 read clears delta", port_delta, 4'h0);
        port_pins[0] = 1'b1; step(3);
        chk("R7 bit7 set", status_o, 8'h80);
        chk("R7 delta pin0", port_delta, 4'b0001);
        step(2);
        chk("R7 held", status_o[7], 1'b1);
        port_chg_rd = 1'b1; step(1); port_chg_rd = 1'b0;
        chk("R7 bit7 clear", status_o[7], 1'b0);
        chk("R7 delta clear", port_delta, 4'h0);
        // R8: change seen in the same cycle as the read
        port_pins[0] = 1'b0; step(2);
        port_chg_rd = 1'b1; step(1); port_chg_rd = 1'b0;
        chk("R8 port set wins", status_o[7], 1'b1);
        chk("R8 delta set wins", port_delta, 4'b0001);

        // R9: reset mid-run clears everything
        ct_ready = 1'b1; step(1); ct_ready = 1'b0;
        rst_n = 1'b0; step(1);
        chk("R9 reset status", status_o, 8'h00);
        chk("R9 reset mask", mask_o, 8'h00);
        chk("R9 reset delta", port_delta, 4'h0);
        rst_n = 1'b1; step(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule